// File: doc/BRIEF.md
# Clock-Driven Continuous Memory Streamer

This block reads a 128-byte memory and shifts its contents, without pause and without any handshake, onto a shared open-drain data line. A dedicated one-way clock input paces the stream. That clock is sampled in the system clock domain, and each detected rising edge moves the stream forward by exactly one bit.

After reset the line stays released through a short synchronization phase. The block then sends the bytes in ascending address order. Each byte goes out most significant bit first, and a released padding bit follows it. After the last address the stream wraps to the first one and carries on for as long as the clock runs.

A mode controller can restart the stream from the first address without repeating the synchronization phase. Streaming only goes on while the two-wire bus clock rests high. Whenever that clock is low, the line is released and the one-way clock is ignored.

Top module: `vclk_streamer`

## Requirements
- R1: While reset is held and right after it, `sda_oe` is 0, `sda_out` is 1 and `mem_addr` is 0.
- R2: For the first nine accepted rising edges of `vclk_in` after reset, `sda_oe` stays 0.
- R3: From the tenth accepted edge on, each accepted edge drives one bit with `sda_oe` = 1. The first bit is bit 7 of address 0, and the bits of a byte go out from bit 7 down to bit 0. Between edges the driven value holds.
- R4: The ninth bit of every frame is a null bit: the edge that follows bit 0 sets `sda_oe` to 0 and `sda_out` to 1.
- R5: `mem_addr` names the byte being sent. It moves up by one on the null-bit edge, wraps from 127 to 0, and changes at no other time except on restart.
- R6: While `bus_clk` is low (after synchronization), `sda_oe` is 0 and `sda_out` is 1. Rising edges of `vclk_in` seen during that time change neither the address nor the bit position.
- R7: A one-cycle pulse on `restart` sets `mem_addr` to 0, releases the line, and makes the next accepted edge drive bit 7 of address 0, without a new nine-edge phase.
- R8: `vclk_in` is asynchronous. It is synchronized, and a high level held for many system clocks counts as one edge only. The output reacts within three system clocks of the input edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vclk_in | input | 1 | One-way stream clock, asynchronous |
| bus_clk | input | 1 | Two-wire bus clock level; high means idle and streaming is allowed |
| restart | input | 1 | Single-cycle pulse from the mode controller |
| mem_addr | output | 7 | Read address into the memory array |
| mem_data | input | 8 | Read data for `mem_addr`, combinational |
| sda_out | output | 1 | Value for the data line when driven |
| sda_oe | output | 1 | 1 drives `sda_out` onto the line, 0 releases it |

## Verification
The bench goes after four kinds of error:
- Miscounting the synchronization phase by one. Such a design releases bit 7 of address 0 an edge early or late, which shifts every later bit of the stream.
- A broken frame boundary. Such a design either skips the null bit or drives data in its place, or fails to wrap after address 127 and reads past the array.
- A restart or bus-busy condition that is not handled. With a broken restart the stream continues from the old position. With a broken bus-busy path the design keeps driving, or counts edges it should have ignored.
- A long high on `vclk_in` that the design treats as several edges, which would run the stream ahead.

// File: rtl/vclk_streamer.sv
module vclk_streamer #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_EDGES  = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vclk_in,
  input  logic              bus_clk,
  input  logic              restart,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_data,
  output logic              sda_out,
  output logic              sda_oe
);
  localparam int BIT_W  = $clog2(DATA_W + 1);
  localparam int INIT_W = $clog2(SYNC_EDGES + 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

  logic [SYNC_STAGES-1:0] vsync, bsync;
  logic                   vprev;
  logic [INIT_W-1:0]      init_cnt;
  logic [BIT_W-1:0]       bit_idx;
  logic [ADDR_W-1:0]      addr;
  logic [DATA_W-1:0]      shifted;

  wire vclk_s    = vsync[SYNC_STAGES-1];
  wire bus_ok    = bsync[SYNC_STAGES-1];
  wire rise      = vclk_s & ~vprev;
  wire init_done = (init_cnt == INIT_W'(SYNC_EDGES));
  wire at_null   = (bit_idx == BIT_W'(DATA_W));

  assign shifted  = mem_data << bit_idx;
  wire   cur_bit  = shifted[DATA_W-1];
  assign mem_addr = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vsync <= '0;
      bsync <= '0;
      vprev <= 1'b0;
    end else begin
      vsync <= {vsync[SYNC_STAGES-2:0], vclk_in};
      bsync <= {bsync[SYNC_STAGES-2:0], bus_clk};
      vprev <= vclk_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_cnt <= '0;
      bit_idx  <= '0;
      addr     <= '0;
      sda_oe   <= 1'b0;
      sda_out  <= 1'b1;
    end else if (restart) begin
      bit_idx <= '0;
      addr    <= '0;
      sda_oe  <= 1'b0;
      sda_out <= 1'b1;
    end else if (!bus_ok) begin
      sda_oe  <= 1'b0;
      sda_out <= 1'b1;
    end else if (rise) begin
      if (!init_done) begin
        init_cnt <= init_cnt + 1'b1;
      end else if (at_null) begin
        sda_oe  <= 1'b0;
        sda_out <= 1'b1;
        bit_idx <= '0;
        addr    <= addr + 1'b1;
      end else begin
        sda_oe  <= 1'b1;
        sda_out <= cur_bit;
        bit_idx <= bit_idx + 1'b1;
      end
    end
  end

  AST_INIT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !sda_oe); // R2
  AST_DATA_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && bus_ok && init_done && !at_null && !restart) |=> (sda_oe && sda_out == $past(cur_bit))); // R3
  AST_NULL_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && bus_ok && init_done && at_null && !restart) |=> (!sda_oe && sda_out)); // R4
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise && bus_ok) && !restart |=> $stable(mem_addr)); // R5
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && bus_ok && init_done && at_null && !restart && addr == LAST_ADDR) |=> (mem_addr == '0)); // R5
  AST_BUS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ok && !restart) |=> (!sda_oe && $stable(mem_addr))); // R6
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (mem_addr == '0 && !sda_oe)); // R7
  AST_ONE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R8
endmodule

// File: tb/sim_vclk_streamer.sv
module sim_vclk_streamer;
  logic clk = 0, rst_n = 0, vclk = 0, bus_clk = 1, restart = 0;
  logic [6:0] mem_addr;
  logic [7:0] mem_data;
  logic sda_out, sda_oe;
  int checks = 0, errors = 0;
  int init_n = 0, m_addr = 0, m_bit = 0;
  logic e_oe = 0, e_out = 1;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] memv(input int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction
  assign mem_data = memv(int'(mem_addr));

  vclk_streamer u0 (.clk(clk), .rst_n(rst_n), .vclk_in(vclk), .bus_clk(bus_clk),
    .restart(restart), .mem_addr(mem_addr), .mem_data(mem_data),
    .sda_out(sda_out), .sda_oe(sda_oe));

  task automatic chk(input string tag);
    checks++;
    if (sda_oe !== e_oe || (e_oe && sda_out !== e_out) || (!e_oe && sda_out !== 1'b1)
        || int'(mem_addr) != m_addr) begin
      errors++;
      $display("FAIL %s: oe=%0b out=%0b addr=%0d expected oe=%0b out=%0b addr=%0d",
               tag, sda_oe, sda_out, mem_addr, e_oe, e_oe ? e_out : 1'b1, m_addr);
    end
  endtask

  function automatic string step();
    string tag;
    if (init_n < 9) begin init_n++; e_oe = 0; e_out = 1; tag = "R2"; end
    else if (m_bit == 8) begin
      e_oe = 0; e_out = 1; m_bit = 0; m_addr = (m_addr + 1) % 128; tag = "R4/R5";
    end else begin
      e_oe = 1; e_out = memv(m_addr)[7 - m_bit]; m_bit++; tag = "R3";
    end
    return tag;
  endfunction

  task automatic vpulse(input int hold, input bit counted, input string force_tag);
    string tag;
    @(negedge clk) vclk = 1;
    tag = counted ? step() : force_tag;
    if (force_tag != "") tag = force_tag;
    repeat (hold) @(negedge clk);
    chk(tag);
    vclk = 0;
    repeat (4) @(negedge clk);
    chk(tag);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R1");
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1");
    for (int i = 0; i < 9; i++) vpulse(4, 1, "");
    for (int i = 0; i < 40; i++) vpulse(4, 1, "");
    @(negedge clk) restart = 1;
    @(negedge clk) restart = 0;
    m_addr = 0; m_bit = 0; e_oe = 0; e_out = 1;
    repeat (2) @(negedge clk);
    chk("R7");
    for (int i = 0; i < 20; i++) vpulse(4, 1, (i == 0) ? "R7" : "");
    @(negedge clk) bus_clk = 0;
    e_oe = 0; e_out = 1;
    repeat (4) @(negedge clk);
    chk("R6");
    for (int i = 0; i < 3; i++) vpulse(4, 0, "R6");
    @(negedge clk) bus_clk = 1;
    repeat (4) @(negedge clk);
    chk("R6");
    for (int i = 0; i < 5; i++) vpulse(4, 1, (i == 0) ? "R6" : "");
    vpulse(30, 1, "R8");
    vpulse(4, 1, "R8");
    for (int i = 0; i < 128 * 9 + 12; i++) vpulse(4, 1, "");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule